// File: doc/BRIEF.md
# Chained Spatial Region Table

The block stores spatial-region records for an instruction prefetcher. A record is keyed by a trigger block address and carries a footprint bitmap of neighbouring blocks. It also carries a pointer to the entry that was inserted right after it, so a consumer can replay a recorded stream by following the pointers from entry to entry. The table is set-associative with least-recently-used replacement.

Storage is saved by not keeping the full tag in each entry. The trigger address is split, from low bits to high bits, into a set index, a short partial tag and a high-order pattern. The high-order pattern lives in a small shared set-associative pattern table, and each main entry holds only the index of its pattern there. Few distinct high-order patterns occur in practice, so many entries share a single pattern.

The block has three ports:
- An insert port records a (trigger, footprint) pair.
- A lookup port searches by trigger and returns hit, footprint, successor pointer and location.
- A read port returns an entry by location, which is how successors are chased.

Top module: `csrt_table`

## Requirements
- R1: After reset every entry and every pattern is invalid. Every lookup misses, every read reports its entry invalid with all read data zero, and the first insert writes no successor pointer.
- R2: A trigger of ADDR_W bits is split as follows:
  - set = bits [SET_W-1:0];
  - partial tag = the next PTAG_W bits;
  - high-order pattern = the remaining upper bits.
  
  A location is {set, way}. A read of a valid entry returns its rebuilt trigger as {stored pattern, partial tag, set}.
- R3: An insert whose trigger hits overwrites only that entry's footprint. Its successor pointer, its successor-valid bit and its location stay unchanged.
- R4: An insert that misses allocates the lowest-numbered invalid way of the set. If the set has no invalid way, it allocates the least recently used way. The new entry holds the footprint and partial tag, the pattern index, and a cleared successor-valid bit.
- R5: Each insert, hit or miss, makes its way the most recently used way of its set. Lookups and reads never change the replacement order.
- R6: Each insert after the first writes the new entry's location into the entry of the previous insert and sets that entry's successor-valid bit. This write is skipped when the two locations are equal.
- R7: An insert whose high-order pattern is absent places the pattern in pattern-table set pattern[PT_SET_W-1:0]. It uses the lowest invalid way, otherwise the least recently used way. Every insert makes its pattern way the most recently used one. The pattern index is {pattern set, way}.
- R8: A lookup hits only when all of the following hold:
  - a valid entry of the trigger's set has the same partial tag;
  - the pattern-table entry that the entry's index names is valid and equals the trigger's high-order pattern.
  
  Entries whose pattern was replaced therefore miss. On a miss the footprint, location, pointer and valid outputs are zero.
- R9: Lookup and read results appear one cycle after the request, with a done pulse. The done pulse is low in every cycle without a request.
- R10: A lookup issued in the same cycle as an insert sees the table as it was before that insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request |
| ins_trig_i | input | ADDR_W | Trigger block address to insert |
| ins_fp_i | input | FP_W | Footprint to store |
| lk_valid_i | input | 1 | Lookup request |
| lk_trig_i | input | ADDR_W | Trigger block address to search |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_fp_o | output | FP_W | Footprint of the hit entry |
| lk_loc_o | output | SET_W+log2(WAYS) | Location {set, way} of the hit entry |
| lk_succ_o | output | SET_W+log2(WAYS) | Successor location of the hit entry |
| lk_succ_vld_o | output | 1 | Successor pointer valid |
| rd_valid_i | input | 1 | Read-by-location request |
| rd_loc_i | input | SET_W+log2(WAYS) | Location to read |
| rd_done_o | output | 1 | Read result valid |
| rd_ent_vld_o | output | 1 | Entry at the location is valid |
| rd_trig_o | output | ADDR_W | Rebuilt trigger of the entry |
| rd_fp_o | output | FP_W | Footprint of the entry |
| rd_succ_o | output | SET_W+log2(WAYS) | Successor location of the entry |
| rd_succ_vld_o | output | 1 | Successor pointer valid |

## Verification
The assertions assume three things about the inputs:
- every request input is at a known level in each cycle;
- inputs are low while reset is applied;
- a location on the read port always names an existing {set, way}, which the power-of-two geometry guarantees.

The stimulus issues at most one request per cycle. The only exception is a single directed cycle that pairs an insert with a lookup.

Triggers are drawn from a narrow pool of sets and high-order patterns. This forces both main-table evictions and pattern-table evictions, so pointer chains, stale entries and set conflicts all occur within a few thousand cycles.

// File: rtl/csrt_pkg.sv
package csrt_pkg;
  localparam int unsigned DEF_ADDR_W   = 20;
  localparam int unsigned DEF_SET_W    = 4;
  localparam int unsigned DEF_WAYS     = 4;
  localparam int unsigned DEF_PTAG_W   = 2;
  localparam int unsigned DEF_PT_SET_W = 2;
  localparam int unsigned DEF_PT_WAYS  = 4;
  localparam int unsigned DEF_FP_W     = 8;
endpackage

// File: rtl/csrt_lru.sv
module csrt_lru #(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] q_set_i,
  output logic [WAY_W-1:0] lru_way_o
);
  // age 0 = most recent, WAYS-1 = victim; ages stay a permutation
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[q_set_i][w] == WAY_W'(WAYS - 1)) lru_way_o = WAY_W'(w);
  end
endmodule

// File: rtl/csrt_pat.sv
module csrt_pat #(
  parameter int unsigned HI_W  = 14,
  parameter int unsigned SET_W = 2,
  parameter int unsigned WAYS  = 4,
  localparam int unsigned SETS  = 1 << SET_W,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned ENT   = SETS * WAYS,
  localparam int unsigned IDX_W = SET_W + WAY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_i,
  input  logic [HI_W-1:0]  hi_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             pat_vld_o [ENT],
  output logic [HI_W-1:0]  pat_hi_o  [ENT]
);
  logic             vld_q [ENT];
  logic [HI_W-1:0]  hi_q  [ENT];
  logic [SET_W-1:0] set;
  logic             hit, free_found;
  logic [WAY_W-1:0] hit_way, free_way, lru_way, sel_way;
  logic [IDX_W-1:0] e;

  assign set = hi_i[SET_W-1:0];

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    free_found = 1'b0;
    free_way = '0;
    e = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      e = {set, WAY_W'(w)};
      if (!vld_q[e]) begin
        free_found = 1'b1;
        free_way = WAY_W'(w);
      end
      if (vld_q[e] && hi_q[e] == hi_i) begin
        hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  assign sel_way = hit ? hit_way : (free_found ? free_way : lru_way);
  assign idx_o   = {set, sel_way};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENT; i++) begin
        vld_q[i] <= 1'b0;
        hi_q[i]  <= '0;
      end
    end else if (ins_i && !hit) begin
      vld_q[idx_o] <= 1'b1;
      hi_q[idx_o]  <= hi_i;
    end
  end

  always_comb begin
    for (int i = 0; i < ENT; i++) begin
      pat_vld_o[i] = vld_q[i];
      pat_hi_o[i]  = hi_q[i];
    end
  end

  csrt_lru #(.SETS(SETS), .WAYS(WAYS)) lru_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (ins_i),
    .touch_set_i (set),
    .touch_way_i (sel_way),
    .q_set_i     (set),
    .lru_way_o   (lru_way)
  );
endmodule

// File: rtl/csrt_table.sv
module csrt_table
  import csrt_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned SET_W    = DEF_SET_W,
  parameter int unsigned WAYS     = DEF_WAYS,
  parameter int unsigned PTAG_W   = DEF_PTAG_W,
  parameter int unsigned PT_SET_W = DEF_PT_SET_W,
  parameter int unsigned PT_WAYS  = DEF_PT_WAYS,
  parameter int unsigned FP_W     = DEF_FP_W,
  localparam int unsigned WAY_W   = $clog2(WAYS),
  localparam int unsigned SETS    = 1 << SET_W,
  localparam int unsigned ENT     = SETS * WAYS,
  localparam int unsigned LOC_W   = SET_W + WAY_W,
  localparam int unsigned HI_W    = ADDR_W - SET_W - PTAG_W,
  localparam int unsigned PIDX_W  = PT_SET_W + $clog2(PT_WAYS),
  localparam int unsigned PT_ENT  = (1 << PT_SET_W) * PT_WAYS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_valid_i,
  input  logic [ADDR_W-1:0] ins_trig_i,
  input  logic [FP_W-1:0]   ins_fp_i,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_trig_i,
  output logic              lk_done_o,
  output logic              lk_hit_o,
  output logic [FP_W-1:0]   lk_fp_o,
  output logic [LOC_W-1:0]  lk_loc_o,
  output logic [LOC_W-1:0]  lk_succ_o,
  output logic              lk_succ_vld_o,
  input  logic              rd_valid_i,
  input  logic [LOC_W-1:0]  rd_loc_i,
  output logic              rd_done_o,
  output logic              rd_ent_vld_o,
  output logic [ADDR_W-1:0] rd_trig_o,
  output logic [FP_W-1:0]   rd_fp_o,
  output logic [LOC_W-1:0]  rd_succ_o,
  output logic              rd_succ_vld_o
);
  logic              mt_vld_q  [ENT];
  logic [PTAG_W-1:0] mt_ptag_q [ENT];
  logic [PIDX_W-1:0] mt_pidx_q [ENT];
  logic [FP_W-1:0]   mt_fp_q   [ENT];
  logic [LOC_W-1:0]  mt_succ_q [ENT];
  logic              mt_svld_q [ENT];
  logic              last_vld_q;
  logic [LOC_W-1:0]  last_loc_q;

  logic              pat_vld [PT_ENT];
  logic [HI_W-1:0]   pat_hi  [PT_ENT];
  logic [PIDX_W-1:0] ins_pidx;

  // full match: set, partial tag, and the pattern the entry points to
  function automatic logic [WAY_W:0] find(input logic [ADDR_W-1:0] t);
    logic [SET_W-1:0]  s;
    logic [PTAG_W-1:0] pt;
    logic [HI_W-1:0]   hi;
    logic [LOC_W-1:0]  e;
    logic [WAY_W:0]    r;
    s  = t[SET_W-1:0];
    pt = t[SET_W +: PTAG_W];
    hi = t[ADDR_W-1 -: HI_W];
    r  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      e = {s, WAY_W'(w)};
      if (mt_vld_q[e] && mt_ptag_q[e] == pt && pat_vld[mt_pidx_q[e]] &&
          pat_hi[mt_pidx_q[e]] == hi)
        r = {1'b1, WAY_W'(w)};
    end
    return r;
  endfunction

  logic [SET_W-1:0]  ins_set;
  logic [WAY_W:0]    ins_m, lk_m;
  logic              ins_hit, free_found;
  logic [WAY_W-1:0]  free_way, lru_way, new_way;
  logic [LOC_W-1:0]  new_loc, fe;

  assign ins_set = ins_trig_i[SET_W-1:0];
  assign ins_m   = find(ins_trig_i);
  assign ins_hit = ins_m[WAY_W];
  assign lk_m    = find(lk_trig_i);

  always_comb begin
    free_found = 1'b0;
    free_way = '0;
    fe = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      fe = {ins_set, WAY_W'(w)};
      if (!mt_vld_q[fe]) begin
        free_found = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  assign new_way = ins_hit ? ins_m[WAY_W-1:0] : (free_found ? free_way : lru_way);
  assign new_loc = {ins_set, new_way};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENT; i++) begin
        mt_vld_q[i]  <= 1'b0;
        mt_ptag_q[i] <= '0;
        mt_pidx_q[i] <= '0;
        mt_fp_q[i]   <= '0;
        mt_succ_q[i] <= '0;
        mt_svld_q[i] <= 1'b0;
      end
      last_vld_q <= 1'b0;
      last_loc_q <= '0;
    end else if (ins_valid_i) begin
      mt_fp_q[new_loc] <= ins_fp_i;
      if (!ins_hit) begin
        mt_vld_q[new_loc]  <= 1'b1;
        mt_ptag_q[new_loc] <= ins_trig_i[SET_W +: PTAG_W];
        mt_pidx_q[new_loc] <= ins_pidx;
        mt_succ_q[new_loc] <= '0;
        mt_svld_q[new_loc] <= 1'b0;
      end
      // link the previous insertion to this one
      if (last_vld_q && last_loc_q != new_loc) begin
        mt_succ_q[last_loc_q] <= new_loc;
        mt_svld_q[last_loc_q] <= 1'b1;
      end
      last_vld_q <= 1'b1;
      last_loc_q <= new_loc;
    end
  end

  logic [LOC_W-1:0] lk_e;
  assign lk_e = {lk_trig_i[SET_W-1:0], lk_m[WAY_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_done_o     <= 1'b0;
      lk_hit_o      <= 1'b0;
      lk_fp_o       <= '0;
      lk_loc_o      <= '0;
      lk_succ_o     <= '0;
      lk_succ_vld_o <= 1'b0;
    end else begin
      lk_done_o <= lk_valid_i;
      if (lk_valid_i) begin
        lk_hit_o      <= lk_m[WAY_W];
        lk_fp_o       <= lk_m[WAY_W] ? mt_fp_q[lk_e] : '0;
        lk_loc_o      <= lk_m[WAY_W] ? lk_e : '0;
        lk_succ_o     <= lk_m[WAY_W] ? mt_succ_q[lk_e] : '0;
        lk_succ_vld_o <= lk_m[WAY_W] && mt_svld_q[lk_e];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_done_o     <= 1'b0;
      rd_ent_vld_o  <= 1'b0;
      rd_trig_o     <= '0;
      rd_fp_o       <= '0;
      rd_succ_o     <= '0;
      rd_succ_vld_o <= 1'b0;
    end else begin
      rd_done_o <= rd_valid_i;
      if (rd_valid_i) begin
        rd_ent_vld_o  <= mt_vld_q[rd_loc_i];
        rd_trig_o     <= mt_vld_q[rd_loc_i] ?
                         {pat_hi[mt_pidx_q[rd_loc_i]], mt_ptag_q[rd_loc_i], rd_loc_i[LOC_W-1:WAY_W]} : '0;
        rd_fp_o       <= mt_vld_q[rd_loc_i] ? mt_fp_q[rd_loc_i] : '0;
        rd_succ_o     <= mt_vld_q[rd_loc_i] ? mt_succ_q[rd_loc_i] : '0;
        rd_succ_vld_o <= mt_vld_q[rd_loc_i] && mt_svld_q[rd_loc_i];
      end
    end
  end

  csrt_lru #(.SETS(SETS), .WAYS(WAYS)) mt_lru_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (ins_valid_i),
    .touch_set_i (ins_set),
    .touch_way_i (new_way),
    .q_set_i     (ins_set),
    .lru_way_o   (lru_way)
  );

  csrt_pat #(.HI_W(HI_W), .SET_W(PT_SET_W), .WAYS(PT_WAYS)) pat_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ins_i     (ins_valid_i),
    .hi_i      (ins_trig_i[ADDR_W-1 -: HI_W]),
    .idx_o     (ins_pidx),
    .pat_vld_o (pat_vld),
    .pat_hi_o  (pat_hi)
  );
endmodule

// File: rtl/csrt_table_chk.sv
module csrt_table_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SET_W  = 4,
  parameter int unsigned WAY_W  = 2,
  parameter int unsigned FP_W   = 8,
  localparam int unsigned LOC_W = SET_W + WAY_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic [ADDR_W-1:0] lk_trig_i,
  input logic              lk_done_o,
  input logic              lk_hit_o,
  input logic [FP_W-1:0]   lk_fp_o,
  input logic [LOC_W-1:0]  lk_loc_o,
  input logic              lk_succ_vld_o,
  input logic              rd_valid_i,
  input logic [LOC_W-1:0]  rd_loc_i,
  input logic              rd_done_o,
  input logic              rd_ent_vld_o,
  input logic [ADDR_W-1:0] rd_trig_o
);
  AST_LK_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_done_o); // R9
  AST_LK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !lk_done_o); // R9
  AST_RD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_done_o); // R9
  AST_HIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> (!lk_hit_o || lk_loc_o[LOC_W-1:WAY_W] == $past(lk_trig_i[SET_W-1:0]))); // R2
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_done_o && !lk_hit_o) |-> (!lk_succ_vld_o && lk_fp_o == '0 && lk_loc_o == '0)); // R8
  AST_RD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> (!rd_ent_vld_o || rd_trig_o[SET_W-1:0] == $past(rd_loc_i[LOC_W-1:WAY_W]))); // R2
endmodule

bind csrt_table csrt_table_chk #(
  .ADDR_W(ADDR_W), .SET_W(SET_W), .WAY_W(WAY_W), .FP_W(FP_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lk_valid_i    (lk_valid_i),
  .lk_trig_i     (lk_trig_i),
  .lk_done_o     (lk_done_o),
  .lk_hit_o      (lk_hit_o),
  .lk_fp_o       (lk_fp_o),
  .lk_loc_o      (lk_loc_o),
  .lk_succ_vld_o (lk_succ_vld_o),
  .rd_valid_i    (rd_valid_i),
  .rd_loc_i      (rd_loc_i),
  .rd_done_o     (rd_done_o),
  .rd_ent_vld_o  (rd_ent_vld_o),
  .rd_trig_o     (rd_trig_o)
);

// File: tb/csrt_table_tb_top.sv
`timescale 1ns/1ps
module csrt_table_tb_top;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          ins_valid = 0, lk_valid = 0, rd_valid = 0;
  logic [AW-1:0] ins_trig = '0, lk_trig = '0;
  logic [7:0]    ins_fp = '0;
  logic [5:0]    rd_loc = '0;
  logic          lk_done, lk_hit, lk_svld, rd_done, rd_ev, rd_svld;
  logic [7:0]    lk_fp, rd_fp;
  logic [5:0]    lk_loc, lk_succ, rd_succ;
  logic [AW-1:0] rd_trig;

  csrt_table dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_valid), .ins_trig_i(ins_trig), .ins_fp_i(ins_fp),
    .lk_valid_i(lk_valid), .lk_trig_i(lk_trig),
    .lk_done_o(lk_done), .lk_hit_o(lk_hit), .lk_fp_o(lk_fp), .lk_loc_o(lk_loc),
    .lk_succ_o(lk_succ), .lk_succ_vld_o(lk_svld),
    .rd_valid_i(rd_valid), .rd_loc_i(rd_loc),
    .rd_done_o(rd_done), .rd_ent_vld_o(rd_ev), .rd_trig_o(rd_trig),
    .rd_fp_o(rd_fp), .rd_succ_o(rd_succ), .rd_succ_vld_o(rd_svld)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model
  bit        mv [64];
  bit [1:0]  mptag [64];
  int        mpidx [64];
  bit [7:0]  mfp [64];
  int        msucc [64];
  bit        msv [64];
  int        mage [64];
  bit        pv [16];
  bit [13:0] ph [16];
  int        page [16];
  int        mlast = 0;
  bit        mlast_v = 0;

  function automatic void m_reset();
    for (int i = 0; i < 64; i++) begin
      mv[i] = 0; mptag[i] = 0; mpidx[i] = 0; mfp[i] = 0; msucc[i] = 0; msv[i] = 0; mage[i] = i % 4;
    end
    for (int i = 0; i < 16; i++) begin
      pv[i] = 0; ph[i] = 0; page[i] = i % 4;
    end
    mlast = 0; mlast_v = 0;
  endfunction

  function automatic void touch_mt(int s, int w);
    int a = mage[s*4+w];
    for (int v = 0; v < 4; v++)
      if (v == w) mage[s*4+v] = 0;
      else if (mage[s*4+v] < a) mage[s*4+v]++;
  endfunction

  function automatic void touch_pt(int s, int w);
    int a = page[s*4+w];
    for (int v = 0; v < 4; v++)
      if (v == w) page[s*4+v] = 0;
      else if (page[s*4+v] < a) page[s*4+v]++;
  endfunction

  function automatic int m_find(logic [AW-1:0] t);
    int s = int'(t[3:0]);
    for (int w = 0; w < 4; w++) begin
      int e = s*4 + w;
      if (mv[e] && mptag[e] == t[5:4] && pv[mpidx[e]] && ph[mpidx[e]] == t[19:6]) return e;
    end
    return -1;
  endfunction

  function automatic void m_insert(logic [AW-1:0] t, logic [7:0] fp);
    int e = m_find(t);
    int ps = int'(t[7:6]);
    int pw = -1;
    int s = int'(t[3:0]);
    for (int w = 3; w >= 0; w--) if (pv[ps*4+w] && ph[ps*4+w] == t[19:6]) pw = w;
    if (pw < 0) begin
      for (int w = 3; w >= 0; w--) if (!pv[ps*4+w]) pw = w;
      if (pw < 0) for (int w = 0; w < 4; w++) if (page[ps*4+w] == 3) pw = w;
      pv[ps*4+pw] = 1; ph[ps*4+pw] = t[19:6];
    end
    touch_pt(ps, pw);
    if (e >= 0) mfp[e] = fp;
    else begin
      int wv = -1;
      for (int w = 3; w >= 0; w--) if (!mv[s*4+w]) wv = w;
      if (wv < 0) for (int w = 0; w < 4; w++) if (mage[s*4+w] == 3) wv = w;
      e = s*4 + wv;
      mv[e] = 1; mptag[e] = t[5:4]; mpidx[e] = ps*4+pw; mfp[e] = fp; msucc[e] = 0; msv[e] = 0;
    end
    if (mlast_v && mlast != e) begin msucc[mlast] = e; msv[mlast] = 1; end
    mlast = e; mlast_v = 1;
    touch_mt(s, e % 4);
  endfunction

  function automatic logic [AW-1:0] mk(int hi, int pt, int s);
    return {14'(hi), 2'(pt), 4'(s)};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_ins(logic [AW-1:0] t, logic [7:0] fp);
    @(negedge clk); ins_valid = 1; ins_trig = t; ins_fp = fp;
    @(negedge clk); ins_valid = 0;
    m_insert(t, fp);
  endtask

  task automatic do_lk(logic [AW-1:0] t, string req);
    int e = m_find(t);
    @(negedge clk); lk_valid = 1; lk_trig = t;
    @(negedge clk); lk_valid = 0;
    chk(req, "lk_done", 32'(lk_done), 1);
    chk(req, "lk_hit", 32'(lk_hit), 32'(e >= 0));
    chk(req, "lk_fp", 32'(lk_fp), e >= 0 ? 32'(mfp[e]) : 0);
    chk(req, "lk_loc", 32'(lk_loc), e >= 0 ? 32'(e) : 0);
    chk(req, "lk_succ_vld", 32'(lk_svld), e >= 0 ? 32'(msv[e]) : 0);
    if (e >= 0 && msv[e]) chk(req, "lk_succ", 32'(lk_succ), 32'(msucc[e]));
  endtask

  task automatic do_rd(int l, string req);
    @(negedge clk); rd_valid = 1; rd_loc = 6'(l);
    @(negedge clk); rd_valid = 0;
    chk(req, "rd_done", 32'(rd_done), 1);
    chk(req, "rd_ent_vld", 32'(rd_ev), 32'(mv[l]));
    chk(req, "rd_trig", 32'(rd_trig), mv[l] ? 32'({ph[mpidx[l]], mptag[l], 4'(l/4)}) : 0);
    chk(req, "rd_fp", 32'(rd_fp), mv[l] ? 32'(mfp[l]) : 0);
    chk(req, "rd_succ_vld", 32'(rd_svld), mv[l] ? 32'(msv[l]) : 0);
    if (mv[l] && msv[l]) chk(req, "rd_succ", 32'(rd_succ), 32'(msucc[l]));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [AW-1:0] a, b, p0;
    m_reset();
    void'($urandom(32'h1d2c));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    do_lk(mk(5, 1, 1), "R1");
    do_rd(0, "R1");
    chk("R9", "lk_done idle", 32'(lk_done), 0);
    a = mk(5, 1, 1); b = mk(5, 2, 1);
    do_ins(a, 8'h11);
    do_lk(a, "R4");
    chk("R2", "first loc {set1,way0}", 32'(lk_loc), 4);
    chk("R1", "first insert no successor", 32'(lk_svld), 0);
    do_ins(b, 8'h22);
    do_lk(a, "R6");
    chk("R6", "A points to B loc 5", 32'(lk_succ), 5);
    do_ins(b, 8'h33);
    do_lk(b, "R6");
    chk("R6", "no self link", 32'(lk_svld), 0);
    chk("R3", "hit fp overwrite", 32'(lk_fp), 8'h33);
    do_ins(a, 8'h44);
    do_lk(a, "R3");
    chk("R3", "successor kept", 32'(lk_succ), 5);
    do_rd(5, "R2");
    chk("R2", "rebuilt trigger", 32'(rd_trig), 32'(b));
    // R4/R5: fill set 1, lookup oldest, then evict
    do_ins(mk(9, 0, 1), 8'h55);
    do_ins(mk(9, 3, 1), 8'h66);
    do_lk(b, "R5");
    do_ins(mk(13, 0, 1), 8'h77);
    do_lk(b, "R5");
    chk("R5", "oldest way evicted despite lookup", 32'(lk_hit), 0);
    do_lk(a, "R4");
    // R7/R8: five patterns in one pattern set
    p0 = mk(3, 0, 8);
    do_ins(p0, 8'h01);
    for (int k = 1; k < 5; k++) do_ins(mk(3 + 4*k, 0, 8 + k), 8'(k));
    do_lk(p0, "R8");
    chk("R8", "stale pattern misses", 32'(lk_hit), 0);
    do_lk(mk(19, 0, 12), "R7");
    // R10: same-cycle insert and lookup
    @(negedge clk); ins_valid = 1; ins_trig = mk(40, 1, 14); ins_fp = 8'h9a;
    lk_valid = 1; lk_trig = mk(40, 1, 14);
    @(negedge clk); ins_valid = 0; lk_valid = 0;
    chk("R10", "lookup sees pre-insert state", 32'(lk_hit), 0);
    m_insert(mk(40, 1, 14), 8'h9a);
    do_lk(mk(40, 1, 14), "R10");
    // random mix
    for (int i = 0; i < 2500; i++) begin
      int op = $urandom_range(0, 9);
      logic [AW-1:0] t = mk($urandom_range(0, 23), $urandom_range(0, 3), $urandom_range(0, 3));
      if (op < 5) do_ins(t, 8'($urandom));
      else if (op < 8) do_lk(t, "R8");
      else do_rd($urandom_range(0, 15), "R6");
    end
    summary();
  end
endmodule